// File: doc/BRIEF.md
# Fixed-Point DDA Scaling Step Generator

This block produces the source coordinates that one display window samples for each output pixel. A configuration pulse loads the source and destination sizes, the source origin, the bytes per pixel, the two flip flags, the transpose flag and the planar flag. A sequential divider then computes one 4.12 fixed-point step per axis and clamps it. After that, two accumulators walk the output raster in order. The horizontal accumulator advances once per output pixel. The vertical accumulator advances once per output line. Each sample leaves on a valid/ready stream as an integer source column and row, each with a 12-bit fractional weight.

The block also presents the values that a fetch unit needs. These are the size of the prescaled window in bytes and lines, and the byte and line offsets where fetching starts. Both offsets take the flips and the planar rule into account. Transposing the window swaps which source and destination dimensions drive each accumulator.

The control is one state machine with four states. IDLE waits for a configuration. LAUNCH starts both dividers. DIVIDE waits for the quotients. STEP emits samples. The transitions are: accept (IDLE to LAUNCH on `cfg_valid`), launch (LAUNCH to DIVIDE, always), ready (DIVIDE to STEP when the divider signals done) and frame end (STEP to IDLE when the last sample is accepted).

Top module: `dda_scale_stepper`

## Requirements
- R1: Each axis step equals ((src − 1) · 4096) / (dst − 1), truncated, as an unsigned 4.12 value.
- R2: The horizontal step is limited to 4.0 (0x4000) and the vertical step to 15.0 (0xF000). A destination size of 0 or 1 on an axis gives that axis its limit.
- R3: When `cfg_transpose` is 1, the horizontal step and the line length come from the source and destination heights. The vertical step and the line count come from the widths. When it is 0, widths drive horizontal and heights drive vertical.
- R4: Both accumulators start at 1.0 (0x1000) at the start of each line or frame. Sample k of a line has out_col·4096 + out_hfrac = k · h_step. Line j has out_row·4096 + out_vfrac = j · v_step.
- R5: Samples leave in raster order, lines of pixels top to bottom. Each frame has exactly (line length × line count) samples, and `out_last` = 1 on the final sample only. While `out_valid` = 1 and `out_ready` = 0, every stream output holds its value.
- R6: `cfg_valid` is taken only in IDLE. A pulse during LAUNCH, DIVIDE or STEP changes neither the steps nor the offsets nor the stream.
- R7: `h_bytes` = (transposed ? src_h : src_w) × bpp, and `v_lines` = (transposed ? src_w : src_h).
- R8: `h_start` = src_x·bpp, plus src_w·bpp − 1 when `cfg_flip_h` = 1. `v_start` = src_y, plus src_h − 1 when `cfg_flip_v` = 1.
- R9: When `cfg_planar` = 1, bit 0 of each start offset is replaced by that axis's flip flag.
- R10: After reset the block is idle: `busy` = 0, `out_valid` = 0, and both steps read 0.
- R11: `out_valid` first rises SZ_W + FRAC_W + 2 rising edges after the edge that accepts the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | One-cycle configuration strobe |
| cfg_src_w | input | SZ_W | Source width in pixels |
| cfg_src_h | input | SZ_W | Source height in lines |
| cfg_dst_w | input | SZ_W | Destination width in pixels |
| cfg_dst_h | input | SZ_W | Destination height in lines |
| cfg_src_x | input | SZ_W | Source origin column |
| cfg_src_y | input | SZ_W | Source origin line |
| cfg_bpp | input | BPP_W | Bytes per pixel |
| cfg_flip_h | input | 1 | Mirror the horizontal axis |
| cfg_flip_v | input | 1 | Mirror the vertical axis |
| cfg_transpose | input | 1 | Swap the axes |
| cfg_planar | input | 1 | Planar YUV offset rule |
| busy | output | 1 | Configuration in progress or frame active |
| h_step | output | INT_W+FRAC_W | Clamped horizontal step (4.12) |
| v_step | output | INT_W+FRAC_W | Clamped vertical step (4.12) |
| h_bytes | output | SZ_W+BPP_W | Prescaled horizontal size in bytes |
| v_lines | output | SZ_W | Prescaled vertical size in lines |
| h_start | output | SZ_W+BPP_W+1 | Starting horizontal byte offset |
| v_start | output | SZ_W+1 | Starting line offset |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_col | output | SZ_W | Integer source column |
| out_hfrac | output | FRAC_W | Horizontal fractional weight |
| out_row | output | SZ_W | Integer source row |
| out_vfrac | output | FRAC_W | Vertical fractional weight |
| out_last | output | 1 | Final sample of the frame |

## Verification
The bench uses the default parameters: 12-bit sizes, a 12-bit fraction and a 4-bit integer part. This makes the dividers take 24 iterations and puts the clamps at 4.0 and 15.0. Source sizes up to 100 then reach both clamps, and the degenerate one-pixel destination is also covered. The frames are a downscale, an upscale, a transposed frame and planar frames. Each frame is checked sample by sample against an independent model, while `out_ready` is throttled by a pseudo-random pattern. A configuration strobe injected while a frame is running shows that such a strobe is ignored.

// File: rtl/dda_pkg.sv
package dda_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_DIVIDE,
        ST_STEP
    } step_state_e;

    typedef enum logic {
        DV_IDLE,
        DV_RUN
    } div_state_e;

endpackage

// File: rtl/dda_divider.sv
module dda_divider #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    import dda_pkg::*;

    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam int PRD_W = NUM_W + DEN_W;

    div_state_e         dst_q, dst_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_W-1:0]   quot_q, num_q;
    logic [DEN_W-1:0]   den_q, rem_q, rem_diff;
    logic [DEN_W:0]     rem_sh;
    logic               fits;

    // One restoring iteration per cycle; a zero divisor yields all ones.
    always_comb begin
        rem_sh   = {rem_q, quot_q[NUM_W-1]};
        fits     = rem_sh >= {1'b0, den_q};
        rem_diff = DEN_W'(rem_sh - {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dst_q <= DV_IDLE;
        else        dst_q <= dst_d;
    end

    always_comb begin
        dst_d = dst_q;
        unique case (dst_q)
            DV_IDLE: if (start)        dst_d = DV_RUN;
            DV_RUN:  if (cnt_q == '0)  dst_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            quot_q <= '0;
            num_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
        end else if (dst_q == DV_IDLE && start) begin
            cnt_q  <= CNT_W'(NUM_W);
            quot_q <= num;
            num_q  <= num;
            den_q  <= den;
            rem_q  <= '0;
        end else if (dst_q == DV_RUN && cnt_q != '0) begin
            quot_q <= {quot_q[NUM_W-2:0], fits};
            rem_q  <= fits ? rem_diff : rem_sh[DEN_W-1:0];
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign done = (dst_q == DV_RUN) && (cnt_q == '0);
    assign quot = quot_q;

    // R1: the finished quotient is the truncated exact quotient
    p_div_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q != '0) |->
            ((PRD_W'(quot_q) * PRD_W'(den_q)) <= PRD_W'(num_q)) &&
            ((PRD_W'(num_q) - PRD_W'(quot_q) * PRD_W'(den_q)) < PRD_W'(den_q)));

endmodule

// File: rtl/dda_axis.sv
module dda_axis #(
    parameter int SZ_W   = 12,
    parameter int FRAC_W = 12,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    output logic [SZ_W-1:0]   idx,
    output logic [FRAC_W-1:0] frac
);
    localparam int ACC_W = SZ_W + FRAC_W + 1;
    localparam int INT_W = ACC_W - FRAC_W;
    localparam logic [ACC_W-1:0] INIT = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [INT_W-1:0] int_part;

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= INIT;
        else if (load) acc_q <= INIT;
        else if (adv)  acc_q <= acc_q + ACC_W'(step);
    end

    always_comb begin
        int_part = acc_q[ACC_W-1:FRAC_W];
        idx      = SZ_W'(int_part - {{(INT_W-1){1'b0}}, 1'b1});
        frac     = acc_q[FRAC_W-1:0];
    end

    // R4: the accumulator never falls below its 1.0 start value
    p_acc_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q >= INIT);

endmodule

// File: rtl/dda_scale_stepper.sv
module dda_scale_stepper #(
    parameter int SZ_W   = 12,
    parameter int FRAC_W = 12,
    parameter int INT_W  = 4,
    parameter int BPP_W  = 3,
    parameter int H_MAX  = 4,
    parameter int V_MAX  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_valid,
    input  logic [SZ_W-1:0]               cfg_src_w,
    input  logic [SZ_W-1:0]               cfg_src_h,
    input  logic [SZ_W-1:0]               cfg_dst_w,
    input  logic [SZ_W-1:0]               cfg_dst_h,
    input  logic [SZ_W-1:0]               cfg_src_x,
    input  logic [SZ_W-1:0]               cfg_src_y,
    input  logic [BPP_W-1:0]              cfg_bpp,
    input  logic                          cfg_flip_h,
    input  logic                          cfg_flip_v,
    input  logic                          cfg_transpose,
    input  logic                          cfg_planar,
    output logic                          busy,
    output logic [INT_W+FRAC_W-1:0]       h_step,
    output logic [INT_W+FRAC_W-1:0]       v_step,
    output logic [SZ_W+BPP_W-1:0]         h_bytes,
    output logic [SZ_W-1:0]               v_lines,
    output logic [SZ_W+BPP_W:0]           h_start,
    output logic [SZ_W:0]                 v_start,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [SZ_W-1:0]               out_col,
    output logic [FRAC_W-1:0]             out_hfrac,
    output logic [SZ_W-1:0]               out_row,
    output logic [FRAC_W-1:0]             out_vfrac,
    output logic                          out_last
);
    import dda_pkg::*;

    localparam int STEP_W  = INT_W + FRAC_W;
    localparam int NUM_W   = SZ_W + FRAC_W;
    localparam int BYTES_W = SZ_W + BPP_W;
    localparam int OFS_W   = BYTES_W + 1;
    localparam int NAXES   = 2;

    step_state_e st_q, st_d;

    // latched configuration
    logic [SZ_W-1:0]  sw_q, sh_q, dw_q, dh_q, sx_q, sy_q;
    logic [BPP_W-1:0] bpp_q;
    logic             fh_q, fv_q, tr_q, pl_q;

    logic [STEP_W-1:0] h_step_q, v_step_q;
    logic [SZ_W-1:0]   x_cnt_q, y_cnt_q;

    // per-axis selection: index 0 horizontal, 1 vertical
    logic [NAXES-1:0][SZ_W-1:0]   ax_src, ax_dst, ax_den;
    logic [NAXES-1:0][NUM_W-1:0]  ax_num, ax_quot;
    logic [NAXES-1:0][STEP_W-1:0] ax_step;
    logic [NAXES-1:0]             ax_done;

    logic div_start, fire, line_end, frame_end, steps_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- transitions ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (cfg_valid)           st_d = ST_LAUNCH;  // accept
            ST_LAUNCH:                          st_d = ST_DIVIDE;  // launch
            ST_DIVIDE: if (ax_done[0])          st_d = ST_STEP;    // ready
            ST_STEP:   if (fire && frame_end)   st_d = ST_IDLE;    // frame end
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        div_start   = 1'b0;
        out_valid   = 1'b0;
        busy        = 1'b1;
        steps_ready = 1'b0;
        unique case (st_q)
            ST_IDLE:   busy        = 1'b0;
            ST_LAUNCH: div_start   = 1'b1;
            ST_DIVIDE: steps_ready = ax_done[0];
            ST_STEP:   out_valid   = 1'b1;
        endcase
    end

    // ---------------- axis mapping ----------------
    always_comb begin
        ax_src[0] = tr_q ? sh_q : sw_q;
        ax_dst[0] = tr_q ? dh_q : dw_q;
        ax_src[1] = tr_q ? sw_q : sh_q;
        ax_dst[1] = tr_q ? dw_q : dh_q;
    end

    for (genvar g = 0; g < NAXES; g++) begin : g_axis
        localparam int LIM_INT = (g == 0) ? H_MAX : V_MAX;
        localparam logic [NUM_W-1:0] LIM = NUM_W'(LIM_INT) << FRAC_W;

        always_comb begin
            ax_num[g]  = (ax_src[g] == '0) ? '0 : (NUM_W'(ax_src[g] - 1'b1) << FRAC_W);
            ax_den[g]  = (ax_dst[g] <= SZ_W'(1)) ? '0 : ax_dst[g] - 1'b1;
            ax_step[g] = (ax_quot[g] > LIM) ? STEP_W'(LIM) : STEP_W'(ax_quot[g]);
        end

        dda_divider #(.NUM_W(NUM_W), .DEN_W(SZ_W)) div_i (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start),
            .num   (ax_num[g]),
            .den   (ax_den[g]),
            .done  (ax_done[g]),
            .quot  (ax_quot[g])
        );
    end

    // ---------------- raster position ----------------
    always_comb begin
        fire      = out_valid && out_ready;
        line_end  = (x_cnt_q == ax_den[0]);
        frame_end = line_end && (y_cnt_q == ax_den[1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0;
            sx_q <= '0; sy_q <= '0; bpp_q <= '0;
            fh_q <= 1'b0; fv_q <= 1'b0; tr_q <= 1'b0; pl_q <= 1'b0;
            h_step_q <= '0;
            v_step_q <= '0;
            x_cnt_q  <= '0;
            y_cnt_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && cfg_valid) begin
                sw_q <= cfg_src_w; sh_q <= cfg_src_h;
                dw_q <= cfg_dst_w; dh_q <= cfg_dst_h;
                sx_q <= cfg_src_x; sy_q <= cfg_src_y;
                bpp_q <= cfg_bpp;
                fh_q <= cfg_flip_h; fv_q <= cfg_flip_v;
                tr_q <= cfg_transpose; pl_q <= cfg_planar;
            end
            if (steps_ready) begin
                h_step_q <= ax_step[0];
                v_step_q <= ax_step[1];
                x_cnt_q  <= '0;
                y_cnt_q  <= '0;
            end else if (fire) begin
                if (line_end) begin
                    x_cnt_q <= '0;
                    y_cnt_q <= y_cnt_q + 1'b1;
                end else begin
                    x_cnt_q <= x_cnt_q + 1'b1;
                end
            end
        end
    end

    dda_axis #(.SZ_W(SZ_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) h_acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (steps_ready || (fire && line_end)),
        .adv   (fire && !line_end),
        .step  (h_step_q),
        .idx   (out_col),
        .frac  (out_hfrac)
    );

    dda_axis #(.SZ_W(SZ_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) v_acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (steps_ready),
        .adv   (fire && line_end && !frame_end),
        .step  (v_step_q),
        .idx   (out_row),
        .frac  (out_vfrac)
    );

    // ---------------- fetch geometry ----------------
    logic [OFS_W-1:0] h_ofs;
    logic [SZ_W:0]    v_ofs;

    always_comb begin
        h_bytes = BYTES_W'(ax_src[0]) * BYTES_W'(bpp_q);
        v_lines = ax_src[1];
        h_ofs   = OFS_W'(OFS_W'(sx_q) * OFS_W'(bpp_q));
        if (fh_q) h_ofs = h_ofs + OFS_W'(OFS_W'(sw_q) * OFS_W'(bpp_q)) - 1'b1;
        v_ofs   = (SZ_W + 1)'(sy_q);
        if (fv_q) v_ofs = v_ofs + (SZ_W + 1)'(sh_q) - 1'b1;
        h_start = pl_q ? {h_ofs[OFS_W-1:1], fh_q} : h_ofs;
        v_start = pl_q ? {v_ofs[SZ_W:1], fv_q} : v_ofs;
    end

    assign out_last = frame_end;
    assign h_step   = h_step_q;
    assign v_step   = v_step_q;

    // ---------------- assertions ----------------
    // R2: steps never exceed their axis limits
    p_step_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_step <= STEP_W'(H_MAX << FRAC_W)) && (v_step <= STEP_W'(V_MAX << FRAC_W)));

    // R5: a stalled sample holds steady
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_col) && $stable(out_row)
            && $stable(out_hfrac) && $stable(out_vfrac) && $stable(out_last));

    // R5: nothing follows the final sample
    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> !out_valid);

    // R4: every frame opens at the source origin
    p_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_col == '0) && (out_hfrac == '0)
            && (out_row == '0) && (out_vfrac == '0));

    // R4: a new line restarts the horizontal accumulator
    p_line_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && line_end && !out_last) |=> (out_col == '0) && (out_hfrac == '0));

    // R6: the latched configuration is frozen outside IDLE
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable({sw_q, sh_q, dw_q, dh_q, sx_q, sy_q,
            bpp_q, fh_q, fv_q, tr_q, pl_q}));

    // R11: both dividers finish together
    p_div_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ax_done[0] == ax_done[1]);

endmodule

// File: tb/dda_scale_stepper_tb.sv
`timescale 1ns/1ps
module dda_scale_stepper_tb_top;

    localparam int SZ_W   = 12;
    localparam int FRAC_W = 12;
    localparam int INT_W  = 4;
    localparam int BPP_W  = 3;
    localparam int LAT    = SZ_W + FRAC_W + 3;  // negedges from strobe to first sample
    localparam longint HLIM = 4 * 4096;
    localparam longint VLIM = 15 * 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [SZ_W-1:0] cfg_src_w = '0, cfg_src_h = '0, cfg_dst_w = '0, cfg_dst_h = '0;
    logic [SZ_W-1:0] cfg_src_x = '0, cfg_src_y = '0;
    logic [BPP_W-1:0] cfg_bpp = '0;
    logic cfg_flip_h = 1'b0, cfg_flip_v = 1'b0, cfg_transpose = 1'b0, cfg_planar = 1'b0;
    logic busy, out_valid, out_last;
    logic out_ready = 1'b0;
    logic [INT_W+FRAC_W-1:0] h_step, v_step;
    logic [SZ_W+BPP_W-1:0] h_bytes;
    logic [SZ_W-1:0] v_lines, out_col, out_row;
    logic [SZ_W+BPP_W:0] h_start;
    logic [SZ_W:0] v_start;
    logic [FRAC_W-1:0] out_hfrac, out_vfrac;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [48:0] sb_q[$];
    logic [7:0] lfsr = 8'hA5;

    always #4 clk = ~clk;

    dda_scale_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
        .cfg_src_w(cfg_src_w), .cfg_src_h(cfg_src_h),
        .cfg_dst_w(cfg_dst_w), .cfg_dst_h(cfg_dst_h),
        .cfg_src_x(cfg_src_x), .cfg_src_y(cfg_src_y), .cfg_bpp(cfg_bpp),
        .cfg_flip_h(cfg_flip_h), .cfg_flip_v(cfg_flip_v),
        .cfg_transpose(cfg_transpose), .cfg_planar(cfg_planar),
        .busy(busy), .h_step(h_step), .v_step(v_step),
        .h_bytes(h_bytes), .v_lines(v_lines), .h_start(h_start), .v_start(v_start),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_col(out_col), .out_hfrac(out_hfrac),
        .out_row(out_row), .out_vfrac(out_vfrac), .out_last(out_last)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint model_step(input longint s, input longint d, input longint lim);
        longint q;
        if (d <= 1) return lim;
        q = ((s == 0 ? 0 : s - 1) * 4096) / (d - 1);
        return (q > lim) ? lim : q;
    endfunction

    // Monitor: throttles ready and compares accepted samples with the scoreboard.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[1];
        if (rst_n && out_valid && out_ready) begin
            logic [48:0] got, exp;
            got = {out_col, out_hfrac, out_row, out_vfrac, out_last};
            if (sb_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R5 unexpected sample: actual=%0h expected=none", got);
            end else begin
                exp = sb_q.pop_front();
                chk("R4/R5", "sample", got, exp);
            end
        end
    end

    task automatic run_frame(input string tag, input int sw, input int sh, input int dw,
                             input int dh, input int sx, input int sy, input int bpp,
                             input bit fh, input bit fv, input bit tr, input bit pl,
                             input bit disturb);
        longint hs, vs, hsrc, hdst, vsrc, vdst, hl, vl, hofs, vofs;
        int cyc;
        hsrc = tr ? sh : sw;  hdst = tr ? dh : dw;
        vsrc = tr ? sw : sh;  vdst = tr ? dw : dh;
        hs = model_step(hsrc, hdst, HLIM);
        vs = model_step(vsrc, vdst, VLIM);
        hl = (hdst <= 1) ? 1 : hdst;
        vl = (vdst <= 1) ? 1 : vdst;
        for (longint j = 0; j < vl; j++) begin
            for (longint k = 0; k < hl; k++) begin
                longint hp, vp;
                hp = k * hs;
                vp = j * vs;
                sb_q.push_back({SZ_W'(hp / 4096), FRAC_W'(hp % 4096),
                                SZ_W'(vp / 4096), FRAC_W'(vp % 4096),
                                (j == vl - 1) && (k == hl - 1)});
            end
        end
        hofs = sx * bpp + (fh ? sw * bpp - 1 : 0);
        vofs = sy + (fv ? sh - 1 : 0);
        if (pl) begin
            hofs = (hofs & ~64'd1) | longint'(fh);
            vofs = (vofs & ~64'd1) | longint'(fv);
        end
        @(negedge clk);
        cfg_src_w = SZ_W'(sw); cfg_src_h = SZ_W'(sh);
        cfg_dst_w = SZ_W'(dw); cfg_dst_h = SZ_W'(dh);
        cfg_src_x = SZ_W'(sx); cfg_src_y = SZ_W'(sy); cfg_bpp = BPP_W'(bpp);
        cfg_flip_h = fh; cfg_flip_v = fv; cfg_transpose = tr; cfg_planar = pl;
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        cyc = 1;
        while (!out_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk("R11", {tag, " first-sample latency"}, cyc, LAT);
        if (disturb) begin
            repeat (10) @(negedge clk);
            // R6: a strobe with different values while stepping must be ignored
            cfg_src_w = 12'd999; cfg_dst_w = 12'd2; cfg_src_h = 12'd999; cfg_dst_h = 12'd2;
            cfg_src_x = 12'd77; cfg_flip_h = ~fh; cfg_transpose = ~tr; cfg_planar = ~pl;
            cfg_valid = 1'b1;
            @(negedge clk);
            cfg_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        chk("R5", {tag, " scoreboard drained"}, sb_q.size(), 0);
        chk("R1/R2/R3", {tag, " h_step"}, h_step, hs);
        chk("R1/R2/R3", {tag, " v_step"}, v_step, vs);
        chk("R7", {tag, " h_bytes"}, h_bytes, hsrc * bpp);
        chk("R7", {tag, " v_lines"}, v_lines, vsrc);
        chk("R8/R9", {tag, " h_start"}, h_start, hofs);
        chk("R8/R9", {tag, " v_start"}, v_start, vofs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        chk("R10", "busy after reset", busy, 0);
        chk("R10", "out_valid after reset", out_valid, 0);
        chk("R10", "h_step after reset", h_step, 0);
        chk("R10", "v_step after reset", v_step, 0);
        // R1 and R8: downscale with both flips
        run_frame("R1 down", 16, 8, 8, 4, 3, 2, 4, 1, 1, 0, 0, 0);
        // R4: upscale, fractional weights
        run_frame("R4 up", 4, 3, 10, 7, 1, 0, 2, 0, 0, 0, 0, 0);
        // R2 and R9: both axes clamp, planar, horizontal flip
        run_frame("R2 clamp", 64, 100, 4, 3, 5, 3, 1, 1, 0, 0, 1, 0);
        // R2: single-pixel destination takes the limits
        run_frame("R2 single", 7, 5, 1, 1, 5, 3, 1, 0, 0, 0, 1, 0);
        // R3 and R6: transposed frame with a strobe injected mid-frame
        run_frame("R3 transpose", 20, 6, 5, 9, 2, 1, 3, 1, 0, 1, 0, 1);
        // R9: planar with both flips
        run_frame("R9 planar", 10, 4, 3, 2, 5, 3, 1, 1, 1, 0, 1, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule